// File: doc/BRIEF.md
# Pending Interrupt Number Resolver

This block sits behind a three-bank interrupt controller and turns its three pending status words into the one interrupt number that software should service next. Bank 0 is a summary word. Its low eight bits are directly attached basic sources. Eleven of its bits are shortcut copies of selected bank 1 and bank 2 lines. Two of its bits show that bank 1 or bank 2 has something pending. Banks 1 and 2 are plain 32-line pending words.

The resolver applies a fixed priority across these groups. It turns a shortcut bit position back into the real line number it stands for, and packs the result as bank times 32 plus line. The result is registered, so the answer for the inputs sampled at one clock edge is on the outputs just after that edge. The logic is evaluated again every cycle, so a higher-priority source that arrives later takes over on the next evaluation. There is no valid output when nothing is pending.

When a bank summary bit is the deciding source but that bank's pending word is empty, the block raises an error flag and does not report a number.

Top module: `pend_resolver`

## Requirements
- R1: While reset is applied and until the first capture after its release, `irq_valid` = 0, `irq_err` = 0 and `irq_num` = 7'h7F.
- R2: Bank 0 bits 21 to 31 have no effect. If bank 0 bits 0 to 20 are all zero, the result is `irq_valid` = 0 and `irq_err` = 0, whatever bank 1 and bank 2 contain.
- R3: If any of bank 0 bits 0 to 7 is set, the lowest set bit among them wins over every other source, and `irq_num` equals that bit index (bank 0).
- R4: Otherwise, if any of bank 0 bits 10 to 14 is set, the lowest one selects the bank 1 line from the sequence 7, 9, 10, 18, 19 (bit 10 gives line 7, bit 14 gives line 19), and `irq_num` = 32 + line. These bits take priority over bits 15 to 20.
- R5: Otherwise, if any of bank 0 bits 15 to 20 is set, the lowest one selects the bank 2 line from the sequence 21, 22, 23, 24, 25, 30 (bit 15 gives 21, bit 20 gives 30), and `irq_num` = 64 + line.
- R6: Otherwise, if bank 0 bit 8 is set and bank 1 is non-zero, `irq_num` = 32 + the index of the lowest set bit of bank 1. This takes priority over bit 9.
- R7: Otherwise, if bank 0 bit 9 is set and bank 2 is non-zero, `irq_num` = 64 + the index of the lowest set bit of bank 2.
- R8: If the deciding source is bit 8 with bank 1 equal to zero, or bit 9 with bank 2 equal to zero, then `irq_err` = 1 and `irq_valid` = 0. If bit 8 is set with bank 1 empty but a higher-priority source exists, no error is flagged.
- R9: The outputs change only at a clock edge and reflect the inputs sampled at that edge (one cycle of latency). A new input pattern on every cycle yields a matching new result on every cycle.
- R10: Whenever `irq_valid` = 0, `irq_num` = 7'h7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| b0_pend | input | 32 | Bank 0 summary pending word |
| b1_pend | input | 32 | Bank 1 pending word |
| b2_pend | input | 32 | Bank 2 pending word |
| irq_valid | output | 1 | A number is being reported |
| irq_num | output | 7 | Bank in bits 6:5, line in bits 4:0; 7'h7F when not valid |
| irq_err | output | 1 | A bank summary decided but its bank word was empty |

## Verification
The bench walks every shortcut position one at a time. A table shifted by one entry, or an index counted from bit 15 rather than bit 10 for bank 2, would give a wrong line number there. It stacks sources of different priorities, such as a basic line with shortcuts, both shortcut banks together, and both summaries together. A swapped priority chain would then report the lower group. It sets only bank 0 bits 21 to 31, which an unmasked design would treat as pending. It also drives a summary with an empty bank word, both as the deciding source and hidden behind a higher one. A design that checked the error condition without regard to priority would then flag a false error. Patterns change on every cycle, so an extra or a missing register stage would shift the results against the scoreboard.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int LINES     = 32;
  localparam int LINE_W    = $clog2(LINES);
  localparam int BANK_W    = 2;
  localparam int NUM_W     = BANK_W + LINE_W;
  localparam int BASIC_N   = 8;
  localparam int SUM1_BIT  = 8;
  localparam int SUM2_BIT  = 9;
  localparam int SC_LSB    = 10;
  localparam int SC1_N     = 5;
  localparam int SC_N      = 11;
  localparam int SC_IW     = $clog2(SC_N);
  localparam int B0_USED_W = SC_LSB + SC_N;

  typedef struct packed {
    logic              valid;
    logic              err;
    logic [NUM_W-1:0]  num;
  } res_t;

  // real line number behind each shortcut slot (slots 0..4 bank 1, 5..10 bank 2)
  function automatic logic [LINE_W-1:0] sc_line(input logic [SC_IW-1:0] slot);
    logic [LINE_W-1:0] l;
    case (slot)
      4'd0:    l = 5'd7;
      4'd1:    l = 5'd9;
      4'd2:    l = 5'd10;
      4'd3:    l = 5'd18;
      4'd4:    l = 5'd19;
      4'd5:    l = 5'd21;
      4'd6:    l = 5'd22;
      4'd7:    l = 5'd23;
      4'd8:    l = 5'd24;
      4'd9:    l = 5'd25;
      4'd10:   l = 5'd30;
      default: l = '1;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/lsb_find.sv
module lsb_find #(
  parameter int W  = 32,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx   = '0;
    found = |vec;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/shortcut_map.sv
module shortcut_map
  import irq_res_pkg::*;
(
  input  logic [SC_N-1:0]   sc_bits,
  output logic              sc_hit,
  output logic [BANK_W-1:0] sc_bank,
  output logic [LINE_W-1:0] sc_ln
);
  logic [SC_IW-1:0] slot;

  lsb_find #(.W(SC_N), .IW(SC_IW)) u_slot (
    .vec   (sc_bits),
    .idx   (slot),
    .found (sc_hit)
  );

  always_comb begin
    sc_ln   = sc_line(slot);
    sc_bank = (slot < SC_IW'(SC1_N)) ? 2'd1 : 2'd2;
  end
endmodule

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/pend_resolver.sv
module pend_resolver
  import irq_res_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  b0_pend,
  input  logic [LINES-1:0]  b1_pend,
  input  logic [LINES-1:0]  b2_pend,
  output logic              irq_valid,
  output logic [NUM_W-1:0]  irq_num,
  output logic              irq_err
);
  localparam logic [NUM_W-1:0] NONE = '1;

  logic rst_s_n;
  rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_s_n));

  logic [B0_USED_W-1:0] b0m;
  logic                 unused_hi;
  assign b0m       = b0_pend[B0_USED_W-1:0];
  assign unused_hi = ^b0_pend[LINES-1:B0_USED_W];

  logic [$clog2(BASIC_N)-1:0] basic_idx;
  logic                       basic_hit;
  lsb_find #(.W(BASIC_N)) u_basic (
    .vec(b0m[BASIC_N-1:0]), .idx(basic_idx), .found(basic_hit));

  logic              sc_hit;
  logic [BANK_W-1:0] sc_bank;
  logic [LINE_W-1:0] sc_ln;
  shortcut_map u_sc (
    .sc_bits(b0m[SC_LSB+SC_N-1:SC_LSB]), .sc_hit(sc_hit),
    .sc_bank(sc_bank), .sc_ln(sc_ln));

  logic [LINE_W-1:0] b1_idx, b2_idx;
  logic              b1_hit, b2_hit;
  lsb_find #(.W(LINES)) u_b1 (.vec(b1_pend), .idx(b1_idx), .found(b1_hit));
  lsb_find #(.W(LINES)) u_b2 (.vec(b2_pend), .idx(b2_idx), .found(b2_hit));

  res_t res_d, res_q;

  // next-state: fixed priority basic > shortcuts > bank1 summary > bank2 summary
  always_comb begin
    res_d = '{valid: 1'b0, err: 1'b0, num: NONE};
    if (basic_hit) begin
      res_d.valid = 1'b1;
      res_d.num   = {2'd0, LINE_W'(basic_idx)};
    end else if (sc_hit) begin
      res_d.valid = 1'b1;
      res_d.num   = {sc_bank, sc_ln};
    end else if (b0m[SUM1_BIT]) begin
      if (b1_hit) begin
        res_d.valid = 1'b1;
        res_d.num   = {2'd1, b1_idx};
      end else begin
        res_d.err   = 1'b1;
      end
    end else if (b0m[SUM2_BIT]) begin
      if (b2_hit) begin
        res_d.valid = 1'b1;
        res_d.num   = {2'd2, b2_idx};
      end else begin
        res_d.err   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) res_q <= '{valid: 1'b0, err: 1'b0, num: NONE};
    else          res_q <= res_d;
  end

  assign irq_valid = res_q.valid;
  assign irq_num   = res_q.num;
  assign irq_err   = res_q.err;

  // assertion support: high once a real capture has happened
  logic past_ok;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) past_ok <= 1'b0;
    else          past_ok <= 1'b1;
  end

  AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_s_n)
    !irq_valid |-> irq_num == NONE); // R10

  AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_err |-> !irq_valid); // R8

  AST_MASK_HIGH: assert property (@(posedge clk) disable iff (!rst_s_n)
    (past_ok && $past(b0_pend[B0_USED_W-1:0]) == '0) |-> (!irq_valid && !irq_err)); // R2

  AST_BASIC_WINS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (past_ok && $past(b0_pend[BASIC_N-1:0]) != '0) |-> (irq_valid && irq_num[NUM_W-1:LINE_W] == 2'd0)); // R3

  AST_SC1_BANK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (past_ok && $past(b0_pend[BASIC_N-1:0]) == '0 && $past(b0_pend[SC_LSB+SC1_N-1:SC_LSB]) != '0)
      |-> (irq_valid && irq_num[NUM_W-1:LINE_W] == 2'd1)); // R4

  AST_SC2_BANK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (past_ok && $past(b0_pend[SC_LSB+SC1_N-1:0]) == '0 && $past(b0_pend[B0_USED_W-1:SC_LSB+SC1_N]) != '0)
      |-> (irq_valid && irq_num[NUM_W-1:LINE_W] == 2'd2)); // R5

  AST_SUM1_EMPTY: assert property (@(posedge clk) disable iff (!rst_s_n)
    (past_ok && $past(b0_pend[SC_LSB-1:0]) == 10'h100 && $past(b0_pend[B0_USED_W-1:SC_LSB]) == '0
      && $past(b1_pend) == '0) |-> irq_err); // R8
endmodule

// File: tb/tb_pend_resolver.sv
module tb_pend_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] b0 = '0, b1 = '0, b2 = '0;
  logic        irq_valid, irq_err;
  logic [6:0]  irq_num;

  always #4 clk = ~clk;

  pend_resolver dut (
    .clk(clk), .rst_n(rst_n), .b0_pend(b0), .b1_pend(b1), .b2_pend(b2),
    .irq_valid(irq_valid), .irq_num(irq_num), .irq_err(irq_err));

  typedef struct {
    logic [8:0] exp;
    string      req;
  } item_t;

  item_t  sbq[$];
  int     n_chk = 0, n_fail = 0;
  bit     done = 1'b0;
  int     sc_tab[11] = '{7, 9, 10, 18, 19, 21, 22, 23, 24, 25, 30};

  function automatic int lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  // {err, valid, num}
  function automatic logic [8:0] model(input logic [31:0] p0, p1, p2);
    logic [31:0] m;
    int k;
    m = p0 & 32'h001F_FFFF;
    if (m == 0) return {2'b00, 7'h7F};
    if (m[7:0] != 0) return {2'b01, 7'(lowest({24'd0, m[7:0]}))};
    if (m[20:10] != 0) begin
      k = lowest({21'd0, m[20:10]});
      return {2'b01, (k < 5) ? 2'd1 : 2'd2, 5'(sc_tab[k])};
    end
    if (m[8]) return (p1 == 0) ? {2'b10, 7'h7F} : {2'b01, 2'd1, 5'(lowest(p1))};
    return (p2 == 0) ? {2'b10, 7'h7F} : {2'b01, 2'd2, 5'(lowest(p2))};
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got err=%0b valid=%0b num=%0d, expected err=%0b valid=%0b num=%0d",
               req, act[8], act[7], act[6:0], exp[8], exp[7], exp[6:0]);
    end
  endtask

  // driver: one pattern per cycle, expected result queued for the monitor
  task automatic drive(input logic [31:0] p0, p1, p2, input string req);
    item_t it;
    @(negedge clk);
    b0 = p0; b1 = p1; b2 = p2;
    it.exp = model(p0, p1, p2);
    it.req = req;
    sbq.push_back(it);
  endtask

  // monitor: result for the pattern captured at this edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        check(it.req, {irq_err, irq_valid, irq_num}, it.exp);
      end
    end
  end

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    b0 = 32'h0000_00FF;
    repeat (3) @(negedge clk);
    check("R1 in reset", {irq_err, irq_valid, irq_num}, {2'b00, 7'h7F});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {irq_err, irq_valid, irq_num}, {2'b00, 7'h7F});
    repeat (3) @(negedge clk);
    sbq.delete();

    drive(32'hFFE0_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 high bits only");
    drive(32'h0000_0028, 0, 0, "R3 basic 3 and 5");
    drive(32'hFFFF_FC81, 32'h1, 32'h1, "R3 basic 0 over all");
    drive(32'h0000_0380, 0, 0, "R3 basic 7 over summaries");
    for (int s = 0; s < 11; s++)
      drive(32'h1 << (10 + s), 32'h1, 32'h1, (s < 5) ? "R4 single shortcut" : "R5 single shortcut");
    drive(32'h0001_1000, 0, 0, "R4 bank1 shortcut over bank2");
    drive(32'h0018_0300, 32'h1, 32'h1, "R5 shortcut over summaries");
    drive(32'h0000_0100, 32'h0001_0100, 0, "R6 bank1 summary");
    drive(32'h0000_0300, 32'h8000_0000, 32'h1, "R6 bit8 over bit9");
    drive(32'h0000_0200, 0, 32'h8000_0000, "R7 bank2 line 31");
    drive(32'h0000_0200, 32'hFFFF_FFFF, 32'h0000_0040, "R7 bank2 line 6");
    drive(32'h0000_0100, 0, 32'h1, "R8 empty bank1");
    drive(32'h0000_0200, 32'h1, 0, "R8 empty bank2");
    drive(32'h0000_0110, 0, 0, "R8 no error behind basic");
    drive(32'h0000_0000, 32'h1, 32'h1, "R10 idle ones");
    drive(32'h0000_0004, 0, 0, "R9 back-to-back a");
    drive(32'h0000_0400, 0, 0, "R9 back-to-back b");
    drive(32'hFFE0_0000, 0, 0, "R2 high bits after activity");
    @(negedge clk);
    @(negedge clk);
    b0 = '0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    done = 1'b1;
    $finish;
  end
endmodule